// File: doc/BRIEF.md
# Scrambling Mode Field Scheduler

This block turns two 4-bit front-panel selector codes into scrambling controls that take effect once per field. One code sets the sync suppression level: clear, 6 dB or 10 dB. The other code sets video inversion. The block takes a field-start strobe, a one-second tick and an optional scene-change pulse. From these it runs the schedule that the selected code asks for:
- a fixed setting,
- a change at a scene cut, allowed only after a minimum dwell,
- a pseudo-random change at the end of a fixed interval counted in seconds,
- a linear test sequence with a 16-field step.

The sync schedule and the video schedule run independently. Each has its own selector register, its own dwell counters and its own pseudo-random generator. Both outputs are registered and change only on a clock cycle where the field strobe is high. This lets the analog path downstream switch suppression depth or polarity cleanly between fields.

Top module: `scramble_field_sched`

## Requirements
- R1: Sync level encoding is 0 = clear, 1 = 6 dB, 2 = 10 dB, and the value 3 never appears. Sync codes 0 and 9 to 15 give clear, code 1 gives 6 dB and code 2 gives 10 dB.
- R2: Video codes 0 and 8 to 15 give inv_en = 0, and code 1 gives constant inv_en = 1.
- R3: Both outputs change only at a rising clock edge where field_stb is high. A new selector code has no effect on the outputs until the next field strobe. At that strobe the output takes the mode's entry value: the fixed value for codes 0, 1, 2 and 9 to 15 (sync) or 0, 1 and 8 to 15 (video), and otherwise clear or not inverted.
- R4: A change of selector code restarts every dwell count of that channel.
- R5: The linear test mode is sync code 8 or video code 7. On every 16th field strobe after entry or after the previous step, it steps sync clear to 6 dB to 10 dB to clear, and toggles inversion.
- R6: The dynamic modes are sync codes 5, 6 and 7 and video codes 4, 5 and 6, with intervals of 15, 30 and 60 second ticks. Once the interval has elapsed since entry or since the last change, the next field strobe applies a new pick. Before that the output holds.
- R7: The field-dwell scene modes are sync code 3 and video code 2. A scene pulse is accepted only once 16 field strobes have passed since entry or since the last change. The change is applied at the next field strobe. Earlier pulses are ignored.
- R8: The second-dwell scene modes are sync code 4 and video code 3. They behave as in R7, but the dwell is 3 second ticks.
- R9: Each pick first advances a 16-bit LFSR that shifts right. When the bit shifted out is 1, the LFSR is XORed with 0xB400. The sync seed is 0xACE1 and the video seed is 0x1D2B, and each LFSR advances only on a pick. With b the new bit 0, the sync level becomes (current + 1 + b) mod 3 and inv_en becomes b.
- R10: Activity on one channel never alters the other channel's output.
- R11: After reset, sync_lvl is 0 and inv_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_stb | input | 1 | One-cycle field-start strobe |
| sec_tick | input | 1 | One-cycle one-second tick |
| scene_pulse | input | 1 | One-cycle scene-cut indication |
| sync_sel | input | 4 | Sync selector code |
| video_sel | input | 4 | Video selector code |
| sync_lvl | output | 2 | Sync suppression level (0 clear, 1 6 dB, 2 10 dB) |
| inv_en | output | 1 | Video inversion enable |

## Verification
The bench builds the block with its default parameters:
- a 16-field dwell,
- a 3-second scene dwell,
- dynamic intervals of 15, 30 and 60 seconds,
- the stated LFSR seeds and mask.

Because second ticks come from a port, the bench can pulse them every few cycles. That brings even the 60-second schedule within a few hundred clocks, so every code can be walked at its real dwell lengths. Knowing the seeds and the mask also lets the bench predict each pseudo-random pick exactly, and confirm that an early scene pulse leaves the sync level unchanged.

// File: rtl/fsched_pkg.sv
package fsched_pkg;

  localparam int SEL_W = 4;
  localparam int LVL_W = 2;

  localparam logic [LVL_W-1:0] LVL_CLEAR = 2'd0;
  localparam logic [LVL_W-1:0] LVL_6DB   = 2'd1;
  localparam logic [LVL_W-1:0] LVL_10DB  = 2'd2;

  typedef enum logic [2:0] {
    K_FIXED     = 3'd0,
    K_SCENE_FLD = 3'd1,
    K_SCENE_SEC = 3'd2,
    K_DYN       = 3'd3,
    K_LINEAR    = 3'd4
  } kind_t;

  // span selects the second limit: 0 scene dwell, 1..3 dynamic intervals
  typedef struct packed {
    kind_t            kind;
    logic [LVL_W-1:0] val;
    logic [1:0]       span;
  } plan_t;

  function automatic plan_t decode_sync(input logic [SEL_W-1:0] c);
    plan_t p;
    p.kind = K_FIXED;
    p.val  = LVL_CLEAR;
    p.span = 2'd0;
    case (c)
      4'd1: p.val = LVL_6DB;
      4'd2: p.val = LVL_10DB;
      4'd3: p.kind = K_SCENE_FLD;
      4'd4: p.kind = K_SCENE_SEC;
      4'd5: begin p.kind = K_DYN; p.span = 2'd1; end
      4'd6: begin p.kind = K_DYN; p.span = 2'd2; end
      4'd7: begin p.kind = K_DYN; p.span = 2'd3; end
      4'd8: p.kind = K_LINEAR;
      default: ;
    endcase
    return p;
  endfunction

  function automatic plan_t decode_video(input logic [SEL_W-1:0] c);
    plan_t p;
    p.kind = K_FIXED;
    p.val  = LVL_CLEAR;
    p.span = 2'd0;
    case (c)
      4'd1: p.val = 2'd1;
      4'd2: p.kind = K_SCENE_FLD;
      4'd3: p.kind = K_SCENE_SEC;
      4'd4: begin p.kind = K_DYN; p.span = 2'd1; end
      4'd5: begin p.kind = K_DYN; p.span = 2'd2; end
      4'd6: begin p.kind = K_DYN; p.span = 2'd3; end
      4'd7: p.kind = K_LINEAR;
      default: ;
    endcase
    return p;
  endfunction

  // random pick: sync moves to one of the two other levels, video takes the bit
  function automatic logic [LVL_W-1:0] pick_next(input logic is_sync,
                                                 input logic [LVL_W-1:0] cur,
                                                 input logic b);
    logic [LVL_W-1:0] r;
    if (is_sync) begin
      case (cur)
        LVL_CLEAR: r = b ? LVL_10DB  : LVL_6DB;
        LVL_6DB:   r = b ? LVL_CLEAR : LVL_10DB;
        default:   r = b ? LVL_6DB   : LVL_CLEAR;
      endcase
    end else begin
      r = {1'b0, b};
    end
    return r;
  endfunction

  function automatic logic [LVL_W-1:0] step_linear(input logic is_sync,
                                                   input logic [LVL_W-1:0] cur);
    logic [LVL_W-1:0] r;
    if (is_sync) r = (cur == LVL_10DB) ? LVL_CLEAR : cur + 2'd1;
    else         r = {1'b0, ~cur[0]};
    return r;
  endfunction

endpackage

// File: rtl/sel_decoder.sv
module sel_decoder
  import fsched_pkg::*;
#(
  parameter bit IS_SYNC = 1'b1
) (
  input  logic [SEL_W-1:0] code,
  output plan_t            plan
);
  generate
    if (IS_SYNC) begin : g_sync
      assign plan = decode_sync(code);
    end else begin : g_video
      assign plan = decode_video(code);
    end
  endgenerate
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int FIELD_DWELL = 16,
  parameter int SEC_W       = 6,
  localparam int FW         = $clog2(FIELD_DWELL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             field_stb,
  input  logic             sec_tick,
  input  logic [SEC_W-1:0] sec_limit,
  output logic             fld_due,
  output logic             fld_met,
  output logic             sec_met
);
  logic [FW-1:0]    fld_cnt;
  logic [SEC_W-1:0] sec_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_cnt <= '0;
      sec_cnt <= '0;
    end else if (clr) begin
      fld_cnt <= '0;
      sec_cnt <= '0;
    end else begin
      if (field_stb && (fld_cnt < FW'(FIELD_DWELL))) fld_cnt <= fld_cnt + 1'b1;
      if (sec_tick && (sec_cnt < sec_limit))         sec_cnt <= sec_cnt + 1'b1;
    end
  end

  assign fld_due = (fld_cnt == FW'(FIELD_DWELL - 1));
  assign fld_met = (fld_cnt == FW'(FIELD_DWELL));
  assign sec_met = (sec_cnt >= sec_limit);

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fld_cnt == '0 && sec_cnt == '0)); // R4
  AST_FIELD_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    fld_cnt <= FW'(FIELD_DWELL)); // R7
  AST_IDLE_FIELD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_stb && !clr) |=> $stable(fld_cnt)); // R5
endmodule

// File: rtl/lfsr_pick.sv
module lfsr_pick #(
  parameter int           W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] MASK = 16'hB400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic pick_bit
);
  logic [W-1:0] state;
  logic [W-1:0] nxt;

  assign nxt      = {1'b0, state[W-1:1]} ^ (state[0] ? MASK : '0);
  assign pick_bit = nxt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= nxt;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R9
  AST_LFSR_ONLY_ON_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state)); // R9
endmodule

// File: rtl/sched_channel.sv
module sched_channel
  import fsched_pkg::*;
#(
  parameter bit          IS_SYNC     = 1'b1,
  parameter int          OUT_W       = 2,
  parameter int          FIELD_DWELL = 16,
  parameter int          SCENE_SECS  = 3,
  parameter int          DYN_SHORT   = 15,
  parameter int          DYN_MID     = 30,
  parameter int          DYN_LONG    = 60,
  parameter int          LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
  parameter logic [LFSR_W-1:0] MASK  = 16'hB400,
  localparam int SEC_MAX0 = (SCENE_SECS > DYN_SHORT) ? SCENE_SECS : DYN_SHORT,
  localparam int SEC_MAX1 = (DYN_MID > DYN_LONG) ? DYN_MID : DYN_LONG,
  localparam int SEC_MAX  = (SEC_MAX0 > SEC_MAX1) ? SEC_MAX0 : SEC_MAX1,
  localparam int SEC_W    = $clog2(SEC_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_stb,
  input  logic             sec_tick,
  input  logic             scene_pulse,
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_W-1:0] out_val
);
  logic [SEL_W-1:0] cur_sel;
  logic             fresh;
  logic             pend;
  logic [LVL_W-1:0] out_q;
  plan_t            plan;
  logic [SEC_W-1:0] sec_limit;
  logic             fld_due, fld_met, sec_met;
  logic             pick_bit;

  // named internal events
  logic sel_chg, strobe_live, entry_evt, run_evt;
  logic scene_kind, dwell_met, step_due, take_evt, accept_evt, adv_evt, clr_evt;
  logic [LVL_W-1:0] entry_val, next_val;

  sel_decoder #(.IS_SYNC(IS_SYNC)) dec_i (.code(cur_sel), .plan(plan));

  always_comb begin
    case (plan.span)
      2'd0:    sec_limit = SEC_W'(SCENE_SECS);
      2'd1:    sec_limit = SEC_W'(DYN_SHORT);
      2'd2:    sec_limit = SEC_W'(DYN_MID);
      default: sec_limit = SEC_W'(DYN_LONG);
    endcase
  end

  dwell_timer #(.FIELD_DWELL(FIELD_DWELL), .SEC_W(SEC_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .field_stb(field_stb),
    .sec_tick(sec_tick), .sec_limit(sec_limit),
    .fld_due(fld_due), .fld_met(fld_met), .sec_met(sec_met));

  lfsr_pick #(.W(LFSR_W), .SEED(SEED), .MASK(MASK)) lfsr_i (
    .clk(clk), .rst_n(rst_n), .adv(adv_evt), .pick_bit(pick_bit));

  assign sel_chg     = (sel != cur_sel);
  assign strobe_live = field_stb && !sel_chg;
  assign entry_evt   = strobe_live && fresh;
  assign run_evt     = strobe_live && !fresh;
  assign scene_kind  = (plan.kind == K_SCENE_FLD) || (plan.kind == K_SCENE_SEC);
  assign dwell_met   = (plan.kind == K_SCENE_FLD) ? fld_met : sec_met;

  always_comb begin
    case (plan.kind)
      K_LINEAR:              step_due = fld_due;
      K_DYN:                 step_due = sec_met;
      K_SCENE_FLD,
      K_SCENE_SEC:           step_due = pend;
      default:               step_due = 1'b0;
    endcase
  end

  assign take_evt   = run_evt && step_due;
  assign accept_evt = scene_pulse && scene_kind && dwell_met && !fresh && !sel_chg;
  assign adv_evt    = take_evt && (plan.kind != K_LINEAR);
  assign clr_evt    = sel_chg || entry_evt || take_evt;
  assign entry_val  = (plan.kind == K_FIXED) ? plan.val : LVL_CLEAR;
  assign next_val   = (plan.kind == K_LINEAR) ? step_linear(IS_SYNC, out_q)
                                              : pick_next(IS_SYNC, out_q, pick_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_sel <= '0;
      fresh   <= 1'b1;
      pend    <= 1'b0;
      out_q   <= LVL_CLEAR;
    end else begin
      cur_sel <= sel;
      if (sel_chg)        fresh <= 1'b1;
      else if (entry_evt) fresh <= 1'b0;
      if (clr_evt)         pend <= 1'b0;
      else if (accept_evt) pend <= 1'b1;
      if (entry_evt)      out_q <= entry_val;
      else if (take_evt)  out_q <= next_val;
    end
  end

  assign out_val = out_q[OUT_W-1:0];

  AST_OUT_ON_FIELD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !field_stb |=> $stable(out_q)); // R3
  AST_SEL_WAITS_FOR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> $stable(out_q)); // R3
  AST_FIXED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_evt && plan.kind == K_FIXED) |=> (out_q == $past(plan.val))); // R1
  AST_EARLY_PULSE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (scene_pulse && !dwell_met && !pend) |=> !pend); // R7
  AST_LINEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_evt && plan.kind == K_LINEAR && !fld_due) |=> $stable(out_q)); // R5
  AST_DYN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_evt && plan.kind == K_DYN && !sec_met) |=> $stable(out_q)); // R6

  generate
    if (IS_SYNC) begin : g_sync_chk
      AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_q != 2'd3); // R1
      AST_PICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (take_evt && plan.kind != K_LINEAR) |=> (out_q != $past(out_q))); // R9
    end else begin : g_video_chk
      AST_INV_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_q[1] == 1'b0); // R2
    end
  endgenerate
endmodule

// File: rtl/scramble_field_sched.sv
module scramble_field_sched
  import fsched_pkg::*;
#(
  parameter int           FIELD_DWELL = 16,
  parameter int           SCENE_SECS  = 3,
  parameter int           DYN_SHORT   = 15,
  parameter int           DYN_MID     = 30,
  parameter int           DYN_LONG    = 60,
  parameter int           LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] LFSR_MASK  = 16'hB400,
  parameter logic [LFSR_W-1:0] SYNC_SEED  = 16'hACE1,
  parameter logic [LFSR_W-1:0] VIDEO_SEED = 16'h1D2B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_stb,
  input  logic             sec_tick,
  input  logic             scene_pulse,
  input  logic [SEL_W-1:0] sync_sel,
  input  logic [SEL_W-1:0] video_sel,
  output logic [LVL_W-1:0] sync_lvl,
  output logic             inv_en
);
  sched_channel #(
    .IS_SYNC(1'b1), .OUT_W(LVL_W), .FIELD_DWELL(FIELD_DWELL),
    .SCENE_SECS(SCENE_SECS), .DYN_SHORT(DYN_SHORT), .DYN_MID(DYN_MID),
    .DYN_LONG(DYN_LONG), .LFSR_W(LFSR_W), .SEED(SYNC_SEED), .MASK(LFSR_MASK)
  ) sync_ch_i (
    .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .sec_tick(sec_tick),
    .scene_pulse(scene_pulse), .sel(sync_sel), .out_val(sync_lvl));

  sched_channel #(
    .IS_SYNC(1'b0), .OUT_W(1), .FIELD_DWELL(FIELD_DWELL),
    .SCENE_SECS(SCENE_SECS), .DYN_SHORT(DYN_SHORT), .DYN_MID(DYN_MID),
    .DYN_LONG(DYN_LONG), .LFSR_W(LFSR_W), .SEED(VIDEO_SEED), .MASK(LFSR_MASK)
  ) video_ch_i (
    .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .sec_tick(sec_tick),
    .scene_pulse(scene_pulse), .sel(video_sel), .out_val(inv_en));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (sync_lvl == 2'd0 && inv_en == 1'b0)); // R11
endmodule

// File: tb/scramble_field_sched_tb.sv
module scramble_field_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       field_stb = 1'b0, sec_tick = 1'b0, scene_pulse = 1'b0;
  logic [3:0] sync_sel = 4'd0, video_sel = 4'd0;
  logic [1:0] sync_lvl;
  logic       inv_en;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] s_lf = 16'hACE1;
  logic [15:0] v_lf = 16'h1D2B;
  int s_cur = 0;

  always #4 clk = ~clk;

  scramble_field_sched dut_i (
    .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .sec_tick(sec_tick),
    .scene_pulse(scene_pulse), .sync_sel(sync_sel), .video_sel(video_sel),
    .sync_lvl(sync_lvl), .inv_en(inv_en));

  function automatic logic [15:0] lf_step(input logic [15:0] s);
    logic [15:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ 16'hB400;
    return r;
  endfunction

  // expected sync pick, restated as modular arithmetic
  function automatic int sync_pick(input int cur);
    s_lf = lf_step(s_lf);
    return (cur + 1 + int'(s_lf[0])) % 3;
  endfunction

  function automatic int video_pick();
    v_lf = lf_step(v_lf);
    return int'(v_lf[0]);
  endfunction

  task automatic chk_sync(input string req, input int exp);
    n_checks++;
    if (int'(sync_lvl) != exp) begin
      n_errors++;
      $display("FAIL %s sync_lvl actual=%0d expected=%0d", req, sync_lvl, exp);
    end
  endtask

  task automatic chk_inv(input string req, input int exp);
    n_checks++;
    if (int'(inv_en) != exp) begin
      n_errors++;
      $display("FAIL %s inv_en actual=%0d expected=%0d", req, inv_en, exp);
    end
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) field_stb = 1'b1;
      @(negedge clk) field_stb = 1'b0;
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
    end
  endtask

  task automatic pulse();
    @(negedge clk) scene_pulse = 1'b1;
    @(negedge clk) scene_pulse = 1'b0;
  endtask

  task automatic set_sel(input logic [3:0] s, input logic [3:0] v);
    @(negedge clk);
    sync_sel = s;
    video_sel = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_sync("R11", 0);
    chk_inv("R11", 0);
  endtask

  task automatic t_static_sync();
    set_sel(4'd1, 4'd0); strobe(1); chk_sync("R1 code1", 1);
    set_sel(4'd2, 4'd0); chk_sync("R3 sel waits", 1);
    strobe(1); chk_sync("R1 code2", 2);
    set_sel(4'd0, 4'd0); strobe(1); chk_sync("R1 code0", 0);
    for (int c = 9; c < 16; c++) begin
      set_sel(4'd2, 4'd0); strobe(1);
      set_sel(4'(c), 4'd0); strobe(1);
      chk_sync("R1 unassigned", 0);
    end
  endtask

  task automatic t_static_video();
    set_sel(4'd0, 4'd1); strobe(1); chk_inv("R2 code1", 1);
    strobe(5); chk_inv("R2 constant", 1);
    for (int c = 8; c < 16; c++) begin
      set_sel(4'd0, 4'd1); strobe(1);
      set_sel(4'd0, 4'(c)); strobe(1);
      chk_inv("R2 unassigned", 0);
    end
    set_sel(4'd0, 4'd0); strobe(1); chk_inv("R2 code0", 0);
  endtask

  task automatic t_linear();
    set_sel(4'd8, 4'd7); strobe(1);
    chk_sync("R5 entry", 0); chk_inv("R5 entry", 0);
    strobe(15); chk_sync("R5 hold", 0); chk_inv("R5 hold", 0);
    strobe(1);  chk_sync("R5 step1", 1); chk_inv("R5 step1", 1);
    strobe(15); chk_sync("R5 hold2", 1);
    strobe(1);  chk_sync("R5 step2", 2); chk_inv("R5 step2", 0);
    strobe(16); chk_sync("R5 wrap", 0); chk_inv("R5 wrap", 1);
  endtask

  task automatic t_reentry();
    set_sel(4'd8, 4'd0); strobe(1); strobe(10);
    chk_sync("R4 mid", 0);
    set_sel(4'd1, 4'd0); chk_sync("R3 no change before strobe", 0);
    strobe(1); chk_sync("R3 new code at strobe", 1);
    set_sel(4'd8, 4'd0); strobe(1); chk_sync("R4 entry clear", 0);
    strobe(15); chk_sync("R4 full dwell restarted", 0);
    strobe(1); chk_sync("R4 step after restart", 1);
  endtask

  task automatic t_dyn_sync();
    int e;
    set_sel(4'd5, 4'd0); strobe(1); s_cur = 0;
    tick(14); strobe(1); chk_sync("R6 before interval", 0);
    tick(1); chk_sync("R3 expiry waits for field", 0);
    strobe(1); e = sync_pick(s_cur); s_cur = e;
    chk_sync("R6 R9 first pick", e);
    tick(15); strobe(1); e = sync_pick(s_cur); s_cur = e;
    chk_sync("R6 R9 second pick", e);
  endtask

  task automatic t_scene_fld();
    int e;
    set_sel(4'd3, 4'd0); strobe(1); s_cur = 0;
    strobe(5); pulse(); strobe(1);
    chk_sync("R7 early pulse ignored", 0);
    strobe(10); strobe(1); chk_sync("R7 no pulse no change", 0);
    pulse(); chk_sync("R3 pulse waits for field", 0);
    strobe(1); e = sync_pick(s_cur); s_cur = e;
    chk_sync("R7 R9 scene change", e);
  endtask

  task automatic t_scene_sec();
    int e;
    set_sel(4'd4, 4'd0); strobe(1); s_cur = 0;
    tick(2); pulse(); strobe(1);
    chk_sync("R8 early pulse ignored", 0);
    tick(1); pulse(); strobe(1);
    e = sync_pick(s_cur); s_cur = e;
    chk_sync("R8 scene change", e);
  endtask

  task automatic t_video_timed();
    int e;
    set_sel(4'd0, 4'd5); strobe(1);
    tick(29); strobe(1); chk_inv("R6 video hold", 0);
    tick(1); strobe(1); e = video_pick();
    chk_inv("R6 R9 video pick", e);
    set_sel(4'd0, 4'd2); strobe(1); chk_inv("R3 video entry", 0);
    strobe(16); pulse(); strobe(1); e = video_pick();
    chk_inv("R7 video scene", e);
  endtask

  task automatic t_indep();
    int e;
    set_sel(4'd7, 4'd1); strobe(1); s_cur = 0;
    chk_inv("R10 video set", 1);
    tick(60); strobe(1); e = sync_pick(s_cur); s_cur = e;
    chk_sync("R10 sync pick", e); chk_inv("R10 video untouched", 1);
    set_sel(4'd7, 4'd0); strobe(1);
    chk_sync("R10 sync untouched by video change", e);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_static_sync();
    t_static_video();
    t_linear();
    t_reentry();
    t_dyn_sync();
    t_scene_fld();
    t_scene_sec();
    t_video_timed();
    t_indep();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule